// File: doc/BRIEF.md
# 16-bit Timer with Compare and Capture on a Byte Bus

The block is a 16-bit up-counter with two output compare channels and one input capture register, all reached over an 8-bit memory-mapped bus. Every 16-bit register is split into a low byte and a high byte. One temporary byte latch is shared by all of them, so a 16-bit value always moves as a whole. To write a register, software writes the high byte first and then the low byte. To read one, it reads the low byte first and then the high byte.

The counter advances on each cycle where the timer clock enable is high. A compare channel fires when the counter equals its compare value on a tick. A firing channel sets its flag and toggles its waveform pin. A capture event is a rising edge on the selected source, which is either a pin or an alternate comparator input. It copies the counter into the capture register. In the capture-as-TOP mode the counter wraps to zero after it reaches the capture value. A software write to the counter suppresses compare matches on the next tick.

Top module: `tmr16_cc`

## Requirements
- R1: After a synchronous reset, all four 16-bit registers read 0, `flags` is 0, `wave` is 0 and `bus_rdata` is 0.
- R2: The register map is: counter at 0x84 (low) / 0x85 (high), capture at 0x86/0x87, compare A at 0x88/0x89, compare B at 0x8A/0x8B. A write to a high address only loads the temporary latch. A write to a low address commits {latch, low byte} to that register in one cycle. Every register reads back what was written.
- R3: Only one temporary latch exists. A high byte written through any register's high address is the high half committed by the next low-byte write, whichever register that write targets.
- R4: A read strobe returns its data on `bus_rdata` one cycle later. A low-address read returns the low byte and copies that register's high byte into the latch in the same cycle. A high-address read returns the latch contents, whichever register loaded it.
- R5: With `top_from_cap` low, the counter increments by one on each cycle with `tick_en` high. It wraps from 0xFFFF to 0, and that wrap sets `flags[0]` (overflow).
- R6: With `top_from_cap` high, a tick with the counter equal to the capture register sends the counter to 0. That wrap does not set the overflow flag.
- R7: On a tick where the counter equals compare A (B), `flags[1]` (`flags[2]`) is set and `wave[0]` (`wave[1]`) toggles, both visible after that clock edge.
- R8: A counter write, and the first tick after it, produce no match on either compare channel. The tick after that matches normally.
- R9: A rising edge on the synchronized source loads the counter value into the capture register and sets `flags[3]`. The source is `cap_pin` when `cap_use_alt` is 0 and `cap_alt` when it is 1.
- R10: A flag stays set until a cycle with its `flag_clr` bit at 1 clears it. Bit order is 0 overflow, 1 compare A, 2 compare B, 3 capture. A set event in the same cycle wins over the clear.
- R11: A falling edge on the selected source, or any edge on the unselected source, leaves the capture register and the capture flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| tick_en | input | 1 | Timer clock enable |
| top_from_cap | input | 1 | 1: counter wraps at the capture value |
| cap_pin | input | 1 | Capture pin source (asynchronous) |
| cap_alt | input | 1 | Alternate comparator source (asynchronous) |
| cap_use_alt | input | 1 | Capture source select |
| flag_clr | input | 4 | Write-one-to-clear flag strobes |
| flags | output | 4 | Overflow, compare A, compare B, capture |
| wave | output | 2 | Compare waveform outputs, A in bit 0 |

## Verification
The assertions take for granted that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that a low-byte write to the capture register does not land in the same cycle as a capture event, since a write would override the event. The stimulus drives every bus strobe for exactly one cycle at a falling edge, with separate read and write tasks. It holds `tick_en` low and waits several cycles after each source change whenever it exercises capture. Reset is held for several clock edges before any property is armed.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int DW    = 8;
  localparam int AW    = 8;
  localparam int RW    = 16;
  localparam int NREG  = 4;
  localparam int IW    = $clog2(NREG);
  localparam int NCMP  = 2;
  localparam int NFLAG = 4;

  // register order follows the address layout
  localparam int REG_CNT = 0;
  localparam int REG_CAP = 1;
  localparam int REG_OCA = 2;

  localparam int FL_OVF  = 0;
  localparam int FL_CMPA = 1;
  localparam int FL_CAP  = 3;

  localparam logic [AW-1:0] BASE_ADDR = 8'h84;
  localparam logic [AW-1:0] SPAN      = AW'(2 * NREG);

  typedef struct packed {
    logic          valid;
    logic [IW-1:0] idx;
    logic          hi;
  } dec_t;

  function automatic dec_t decode(input logic [AW-1:0] a);
    dec_t d;
    logic [AW-1:0] off;
    off     = a - BASE_ADDR;
    d.valid = (a >= BASE_ADDR) && (off < SPAN);
    d.idx   = off[IW:1];
    d.hi    = off[0];
    return d;
  endfunction
endpackage

// File: rtl/tmr16_regif.sv
module tmr16_regif
  import tmr16_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [AW-1:0]             addr,
  input  logic                      wr,
  input  logic [DW-1:0]             wdata,
  input  logic                      rd,
  input  logic [NREG-1:0][RW-1:0]   reg_q,
  output logic [DW-1:0]             rdata,
  output logic [NREG-1:0]           commit,
  output logic [RW-1:0]             commit_val
);
  dec_t          d;
  logic [DW-1:0] temp;

  assign d          = decode(addr);
  assign commit_val = {temp, wdata};

  always_comb begin
    commit = '0;
    if (wr && d.valid && !d.hi) commit[d.idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      temp  <= '0;
      rdata <= '0;
    end else if (wr) begin
      if (d.valid && d.hi) temp <= wdata;
    end else if (rd) begin
      if (!d.valid) begin
        rdata <= '0;
      end else if (!d.hi) begin
        rdata <= reg_q[d.idx][DW-1:0];
        temp  <= reg_q[d.idx][RW-1:DW];
      end else begin
        rdata <= temp;
      end
    end
  end

  // R3: a high-byte write lands in the shared latch
  a_r3_latch_load: assert property (@(posedge clk) disable iff (rst)
    (wr && d.valid && d.hi) |=> (temp == $past(wdata)));

  // R4: a high-byte read returns the latch as it stood
  a_r4_read_high: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr && d.valid && d.hi) |=> (rdata == $past(temp)));
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
  import tmr16_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          top_mode,
  input  logic [RW-1:0] top_val,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_val,
  output logic [RW-1:0] cnt_q,
  output logic          ovf_pulse,
  output logic          cmp_ok
);
  logic blk;

  assign ovf_pulse = tick && !wr_en && !top_mode && (cnt_q == {RW{1'b1}});
  assign cmp_ok    = tick && !wr_en && !blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      blk   <= 1'b0;
    end else if (wr_en) begin
      cnt_q <= wr_val;
      blk   <= 1'b1;
    end else if (tick) begin
      blk <= 1'b0;
      if (top_mode && (cnt_q == top_val)) cnt_q <= '0;
      else                                cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && !top_mode && cnt_q == {RW{1'b1}}) |=> (cnt_q == '0));

  a_r6_top_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && top_mode && cnt_q == top_val) |=> (cnt_q == '0));

  a_r8_block_armed: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !cmp_ok);
endmodule

// File: rtl/tmr16_cmp.sv
module tmr16_cmp
  import tmr16_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_val,
  input  logic [RW-1:0] cnt,
  input  logic          cmp_ok,
  output logic [RW-1:0] ocr_q,
  output logic          match,
  output logic          wave
);
  assign match = cmp_ok && (cnt == ocr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ocr_q <= '0;
      wave  <= 1'b0;
    end else begin
      if (wr_en) ocr_q <= wr_val;
      if (match) wave  <= ~wave;
    end
  end

  a_r7_toggle: assert property (@(posedge clk) disable iff (rst)
    match |=> (wave != $past(wave)));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !match |=> $stable(wave));
endmodule

// File: rtl/tmr16_capture.sv
module tmr16_capture
  import tmr16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin,
  input  logic          alt,
  input  logic          use_alt,
  input  logic [RW-1:0] cnt,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_val,
  output logic [RW-1:0] icr_q,
  output logic          evt
);
  logic [SYNC_STAGES:0] sh;
  logic                 src;

  assign src = use_alt ? alt : pin;
  assign evt = sh[SYNC_STAGES-1] && !sh[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      icr_q <= '0;
    end else begin
      sh <= {sh[SYNC_STAGES-1:0], src};
      if (wr_en)    icr_q <= wr_val;
      else if (evt) icr_q <= cnt;
    end
  end

  a_r9_cap_load: assert property (@(posedge clk) disable iff (rst)
    (evt && !wr_en) |=> (icr_q == $past(cnt)));

  a_r11_no_event_hold: assert property (@(posedge clk) disable iff (rst)
    (!evt && !wr_en) |=> $stable(icr_q));
endmodule

// File: rtl/tmr16_cc.sv
module tmr16_cc
  import tmr16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_rd,
  output logic [DW-1:0]    bus_rdata,
  input  logic             tick_en,
  input  logic             top_from_cap,
  input  logic             cap_pin,
  input  logic             cap_alt,
  input  logic             cap_use_alt,
  input  logic [NFLAG-1:0] flag_clr,
  output logic [NFLAG-1:0] flags,
  output logic [NCMP-1:0]  wave
);
  logic [NREG-1:0][RW-1:0] reg_q;
  logic [NREG-1:0]         commit;
  logic [RW-1:0]           commit_val;
  logic [RW-1:0]           cnt_q;
  logic [RW-1:0]           icr_q;
  logic [NCMP-1:0][RW-1:0] ocr_q;
  logic [NCMP-1:0]         match;
  logic                    cmp_ok;
  logic                    ovf_pulse;
  logic                    cap_evt;
  logic [NFLAG-1:0]        set_v;

  assign reg_q[REG_CNT] = cnt_q;
  assign reg_q[REG_CAP] = icr_q;

  tmr16_regif u_regif (
    .clk        (clk),
    .rst        (rst),
    .addr       (bus_addr),
    .wr         (bus_wr),
    .wdata      (bus_wdata),
    .rd         (bus_rd),
    .reg_q      (reg_q),
    .rdata      (bus_rdata),
    .commit     (commit),
    .commit_val (commit_val)
  );

  tmr16_counter u_counter (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_en),
    .top_mode  (top_from_cap),
    .top_val   (icr_q),
    .wr_en     (commit[REG_CNT]),
    .wr_val    (commit_val),
    .cnt_q     (cnt_q),
    .ovf_pulse (ovf_pulse),
    .cmp_ok    (cmp_ok)
  );

  for (genvar ch = 0; ch < NCMP; ch++) begin : g_cmp
    assign reg_q[REG_OCA+ch] = ocr_q[ch];
    tmr16_cmp u_cmp (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (commit[REG_OCA+ch]),
      .wr_val (commit_val),
      .cnt    (cnt_q),
      .cmp_ok (cmp_ok),
      .ocr_q  (ocr_q[ch]),
      .match  (match[ch]),
      .wave   (wave[ch])
    );
  end

  tmr16_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .pin     (cap_pin),
    .alt     (cap_alt),
    .use_alt (cap_use_alt),
    .cnt     (cnt_q),
    .wr_en   (commit[REG_CAP]),
    .wr_val  (commit_val),
    .icr_q   (icr_q),
    .evt     (cap_evt)
  );

  always_comb begin
    set_v                          = '0;
    set_v[FL_OVF]                  = ovf_pulse;
    set_v[FL_CMPA+NCMP-1:FL_CMPA]  = match;
    set_v[FL_CAP]                  = cap_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~flag_clr) | set_v;
  end

  // R8: no compare channel fires on the tick after a counter write
  a_r8_no_match_after_wr: assert property (@(posedge clk) disable iff (rst)
    commit[REG_CNT] |=> (match == '0));

  // R10: a flag drops only through its clear strobe
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(flags) & ~$past(flag_clr) & ~flags) == '0));

  // R9: a capture event is reflected in the capture flag
  a_r9_cap_flag: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> flags[FL_CAP]);
endmodule

// File: tb/tmr16_cc_tb.sv
`timescale 1ns/100ps
module tmr16_cc_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       tick_en = 1'b0;
  logic       top_from_cap = 1'b0;
  logic       cap_pin = 1'b0;
  logic       cap_alt = 1'b0;
  logic       cap_use_alt = 1'b0;
  logic [3:0] flag_clr = '0;
  logic [3:0] flags;
  logic [1:0] wave;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tmr16_cc u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .top_from_cap(top_from_cap), .cap_pin(cap_pin),
    .cap_alt(cap_alt), .cap_use_alt(cap_use_alt), .flag_clr(flag_clr),
    .flags(flags), .wave(wave)
  );

  // {low address, 16-bit value}
  localparam logic [23:0] VEC [4] = '{
    24'h84_BEEF, 24'h86_5A01, 24'h88_00C3, 24'h8A_F00D
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic write16(input logic [7:0] lo, input logic [15:0] v);
    bus_write(lo + 8'd1, v[15:8]);
    bus_write(lo, v[7:0]);
  endtask

  task automatic read16(input logic [7:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    bus_read(lo, l);
    bus_read(lo + 8'd1, h);
    v = {h, l};
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_clr = 4'hF;
    @(negedge clk);
    flag_clr = 4'h0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 flags", flags, 4'h0);
    check("R1 wave", wave, 2'b00);
    check("R1 rdata", bus_rdata, 8'h00);
    for (int i = 0; i < 4; i++) begin
      read16(8'h84 + 8'(2 * i), v);
      check("R1 register", v, 16'h0000);
    end

    // R2: vector table of write / read-back pairs
    for (int i = 0; i < 4; i++) begin
      write16(VEC[i][23:16], VEC[i][15:0]);
      read16(VEC[i][23:16], v);
      check("R2 readback", v, VEC[i][15:0]);
    end

    // R3: high byte through compare A's address, low byte to compare B
    bus_write(8'h89, 8'hAB);
    bus_write(8'h8A, 8'h5C);
    read16(8'h8A, v);
    check("R3 shared latch commit", v, 16'hAB5C);
    read16(8'h88, v);
    check("R3 other register intact", v, 16'h00C3);

    // R4: low read of compare B loads latch; counter high read returns it
    bus_read(8'h8A, b);
    check("R4 low byte", b, 8'h5C);
    bus_read(8'h85, b);
    check("R4 latch from other register", b, 8'hAB);

    // set up compare values for counting tests
    write16(8'h88, 16'h0100);
    write16(8'h8A, 16'h0102);
    clear_flags();

    // R5: count and overflow
    write16(8'h84, 16'hFFFE);
    run_ticks(1);
    check("R5 no overflow before wrap", flags[0], 1'b0);
    run_ticks(2);
    check("R5 overflow flag", flags[0], 1'b1);
    read16(8'h84, v);
    check("R5 count after wrap", v, 16'h0001);

    // R10: sticky, then cleared by strobe
    repeat (3) @(negedge clk);
    check("R10 flag holds", flags[0], 1'b1);
    clear_flags();
    check("R10 flag cleared", flags, 4'h0);

    // R7: compare A at tick 3, compare B at tick 5
    write16(8'h84, 16'h00FE);
    run_ticks(3);
    check("R7 compare A flag", flags[2:1], 2'b01);
    check("R7 wave A toggled", wave, 2'b01);
    run_ticks(2);
    check("R7 compare B flag", flags[2:1], 2'b11);
    check("R7 wave B toggled", wave, 2'b11);

    // R8: counter write blocks the next tick's match
    clear_flags();
    write16(8'h84, 16'h0100);
    run_ticks(1);
    write16(8'h84, 16'h0102);
    run_ticks(1);
    check("R8 no flags after blocked ticks", flags, 4'h0);
    check("R8 waves unchanged", wave, 2'b11);
    write16(8'h84, 16'h00FF);
    run_ticks(2);
    check("R8 match resumes on second tick", flags[2:1], 2'b01);
    check("R8 wave A toggled back", wave, 2'b10);

    // R6: capture value as TOP
    clear_flags();
    write16(8'h86, 16'h0005);
    write16(8'h84, 16'h0003);
    top_from_cap = 1'b1;
    run_ticks(4);
    top_from_cap = 1'b0;
    read16(8'h84, v);
    check("R6 wrap at TOP", v, 16'h0001);
    check("R6 no overflow flag", flags[0], 1'b0);

    // R9: capture from pin
    clear_flags();
    write16(8'h84, 16'h1234);
    @(negedge clk) cap_pin = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 capture flag", flags[3], 1'b1);
    read16(8'h86, v);
    check("R9 captured pin value", v, 16'h1234);

    // R11: falling edge does nothing
    clear_flags();
    write16(8'h84, 16'h2222);
    @(negedge clk) cap_pin = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 falling edge flag", flags[3], 1'b0);
    read16(8'h86, v);
    check("R11 falling edge value", v, 16'h1234);

    // R9: alternate source
    @(negedge clk) cap_use_alt = 1'b1;
    write16(8'h84, 16'h3333);
    @(negedge clk) cap_alt = 1'b1;
    repeat (5) @(negedge clk);
    read16(8'h86, v);
    check("R9 captured alternate value", v, 16'h3333);

    // R11: edge on unselected pin
    clear_flags();
    write16(8'h84, 16'h4444);
    @(negedge clk) cap_pin = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 unselected flag", flags[3], 1'b0);
    read16(8'h86, v);
    check("R11 unselected value", v, 16'h3333);

    finish_run();
  end
endmodule